// File: doc/BRIEF.md
# Program-Space Data Window Mapper

This block sits on the data-read path of a 16-bit processor, next to a program memory that is 24 bits wide. A data read whose address has its top bit set, made while the window is enabled and no table transfer is running, is turned into a program-memory fetch. The page register supplies the upper address bits. Only the low 16 bits of the fetched word come back as read data. Every other read is passed to ordinary data memory at once, with no stall.

A mapped read costs extra cycles. The count depends on the decoded instruction class and on the hardware repeat-loop context that arrive with the request. While the penalty runs, the block raises `stall` and drops `req_ready`. When the stall ends, it returns the data with a one-cycle `rsp_valid` strobe.

Back-pressure rules:
- A request is taken in a cycle where `req_valid` and `req_ready` are both high.
- `req_ready` is low exactly while `stall` is high.
- A new request may be taken in the same cycle as the strobe of the previous one.
- The response has no ready signal: the core must take `rsp_data` in the cycle `rsp_valid` is high.

The program memory returns `pm_rdata` one cycle after a cycle with `pm_rd` high, and holds it until the next fetch.

Top module: `pgwin_mapper`

## Requirements
- R1: A taken request is mapped if and only if `req_addr[15]`=1, the enable bit is 1 and `tbl_busy`=0. A mapped request raises `pm_rd` in the cycle it is taken. Any other taken request raises `dm_fwd` in that cycle, and produces no `pm_rd`, no `stall` and no `rsp_valid`.
- R2: During `pm_rd`, `pm_addr` is formed as follows: bit 23 is 0, bits 22:15 hold the page register, and bits 14:0 equal `req_addr[14:0]`.
- R3: `rsp_data` equals bits 15:0 of the word returned for the fetch. Bits 23:16 of that word never reach the output.
- R4: With `loop_active`=0, a mapped read stalls 1 cycle when `req_fast_cls`=1 (multiply-accumulate or move class) and 2 cycles otherwise. The iteration flags are ignored in this case.
- R5: With `loop_active`=1, a mapped read stalls 2 cycles if any of `iter_first`, `iter_last`, `iter_irq_exit` or `iter_reentry` is 1, and 0 cycles otherwise. `req_fast_cls` is ignored in this case.
- R6: Let P be the stall length of a mapped read taken in cycle 0. Then `stall` is high in cycles 1..P, `rsp_valid` is high for exactly cycle P+1, and `req_ready` is low exactly while `stall` is high.
- R7: While `tbl_busy`=1, no request is mapped, whatever its address or the enable bit.
- R8: A write with `cfg_sel`=0 loads the page from `cfg_wdata[7:0]`. A write with `cfg_sel`=1 loads the enable from `cfg_wdata[0]`. A write in the same cycle a request is taken affects only later requests.
- R9: After reset the page is 0 and the enable is 0, and `stall`=0, `rsp_valid`=0, `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the page register, 1 selects the enable bit |
| cfg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Data read request valid |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 16 | Data effective address |
| req_fast_cls | input | 1 | Instruction is multiply-accumulate or move class |
| tbl_busy | input | 1 | Table read or write in progress |
| loop_active | input | 1 | Request is inside a hardware repeat loop |
| iter_first | input | 1 | First loop iteration |
| iter_last | input | 1 | Last loop iteration |
| iter_irq_exit | input | 1 | Iteration that leaves the loop for an interrupt |
| iter_reentry | input | 1 | Iteration that resumes the loop after an interrupt |
| dm_fwd | output | 1 | Taken request goes to normal data memory |
| pm_rd | output | 1 | Program-memory fetch strobe |
| pm_addr | output | 24 | Program-memory address |
| pm_rdata | input | 24 | Program-memory word, one cycle after `pm_rd` |
| stall | output | 1 | Stall request to the core |
| rsp_valid | output | 1 | Mapped read data valid, one-cycle strobe |
| rsp_data | output | 16 | Mapped read data |

## Verification
The checker watches several rules on every cycle:
- `pm_rd` and `dm_fwd` are never high together.
- Low addresses and table-busy cycles never raise `pm_rd`.
- The low address bits pass through unchanged and bit 23 is 0.
- A stall never starts without a fetch and never lasts more than two cycles.
- Every falling edge of `stall` brings a strobe, and a mid-loop fetch is never followed by a stall.

Only the bench scenarios can show the rest:
- the exact penalty chosen for each class and iteration combination;
- which page value a fetch uses around a register write;
- that the returned data comes from the right word, with its upper byte dropped.

// File: rtl/pgwin_pkg.sv
package pgwin_pkg;
  // decoded loop context carried with each request
  typedef struct packed {
    logic active;
    logic first;
    logic last;
    logic irq_exit;
    logic reentry;
  } loop_ctx_t;

  // register select codes on the write port
  localparam logic CFG_PAGE = 1'b0;
  localparam logic CFG_EN   = 1'b1;
endpackage

// File: rtl/pgwin_cfg.sv
module pgwin_cfg #(
  parameter int PAGE_W = 8,
  parameter int WD_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WD_W-1:0]   cfg_wdata,
  output logic [PAGE_W-1:0] page_q,
  output logic              en_q
);
  import pgwin_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      en_q   <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_PAGE) page_q <= cfg_wdata[PAGE_W-1:0];
      else                     en_q   <= cfg_wdata[0];
    end
  end
endmodule

// File: rtl/pgwin_xlate.sv
module pgwin_xlate #(
  parameter int DA_W   = 16,
  parameter int PAGE_W = 8,
  parameter int PA_W   = 24
) (
  input  logic [DA_W-1:0]   addr,
  input  logic              en,
  input  logic              tbl_busy,
  input  logic [PAGE_W-1:0] page,
  output logic              hit,
  output logic [PA_W-1:0]   pm_addr
);
  localparam int OFF_W = DA_W - 1;
  localparam int PAD_W = PA_W - PAGE_W - OFF_W;

  assign hit = addr[DA_W-1] & en & ~tbl_busy;

  generate
    if (PAD_W > 0) begin : g_pad
      assign pm_addr = {{PAD_W{1'b0}}, page, addr[OFF_W-1:0]};
    end else begin : g_nopad
      assign pm_addr = {page, addr[OFF_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/pgwin_cost.sv
module pgwin_cost #(
  parameter int FAST_PEN  = 1,
  parameter int SLOW_PEN  = 2,
  parameter int EDGE_PEN  = 2,
  parameter int BODY_PEN  = 0,
  parameter int CNT_W     = 2
) (
  input  pgwin_pkg::loop_ctx_t ctx,
  input  logic                 fast_cls,
  output logic [CNT_W-1:0]     pen
);
  logic edge_iter;
  assign edge_iter = ctx.first | ctx.last | ctx.irq_exit | ctx.reentry;

  always_comb begin
    if (ctx.active) pen = edge_iter ? CNT_W'(EDGE_PEN) : CNT_W'(BODY_PEN);
    else            pen = fast_cls  ? CNT_W'(FAST_PEN) : CNT_W'(SLOW_PEN);
  end
endmodule

// File: rtl/pgwin_seq.sv
module pgwin_seq #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_map,
  input  logic [CNT_W-1:0]  pen,
  input  logic [DATA_W-1:0] word_lo,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q;
  logic              fresh_q;
  logic [DATA_W-1:0] hold_q;

  assign busy      = (cnt_q != '0);
  assign rsp_valid = pend_q & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      fresh_q <= 1'b0;
      hold_q  <= '0;
    end else begin
      fresh_q <= take_map;
      if (fresh_q) hold_q <= word_lo;
      if (take_map)  cnt_q <= pen;
      else if (busy) cnt_q <= cnt_q - 1'b1;
      if (take_map)       pend_q <= 1'b1;
      else if (rsp_valid) pend_q <= 1'b0;
    end
  end

  always_comb begin
    if (!rsp_valid)   rsp_data = '0;
    else if (fresh_q) rsp_data = word_lo;
    else              rsp_data = hold_q;
  end
endmodule

// File: rtl/pgwin_mapper.sv
module pgwin_mapper #(
  parameter int DA_W     = 16,
  parameter int PAGE_W   = 8,
  parameter int PA_W     = 24,
  parameter int PW_W     = 24,
  parameter int MAX_PEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DA_W-1:0]   req_addr,
  input  logic              req_fast_cls,
  input  logic              tbl_busy,
  input  logic              loop_active,
  input  logic              iter_first,
  input  logic              iter_last,
  input  logic              iter_irq_exit,
  input  logic              iter_reentry,
  output logic              dm_fwd,
  output logic              pm_rd,
  output logic [PA_W-1:0]   pm_addr,
  input  logic [PW_W-1:0]   pm_rdata,
  output logic              stall,
  output logic              rsp_valid,
  output logic [DA_W-1:0]   rsp_data
);
  import pgwin_pkg::*;

  localparam int CNT_W = $clog2(MAX_PEN + 1);

  logic [PAGE_W-1:0] page_q;
  logic              en_q;
  logic              hit;
  logic              take;
  logic [CNT_W-1:0]  pen;
  logic              busy;
  loop_ctx_t         ctx;
  logic              unused_hi;

  assign ctx = '{active: loop_active, first: iter_first, last: iter_last,
                 irq_exit: iter_irq_exit, reentry: iter_reentry};

  pgwin_cfg #(.PAGE_W(PAGE_W), .WD_W(8)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .page_q(page_q), .en_q(en_q)
  );

  pgwin_xlate #(.DA_W(DA_W), .PAGE_W(PAGE_W), .PA_W(PA_W)) u_xlate (
    .addr(req_addr), .en(en_q), .tbl_busy(tbl_busy), .page(page_q),
    .hit(hit), .pm_addr(pm_addr)
  );

  pgwin_cost #(.CNT_W(CNT_W)) u_cost (
    .ctx(ctx), .fast_cls(req_fast_cls), .pen(pen)
  );

  pgwin_seq #(.DATA_W(DA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .take_map(pm_rd), .pen(pen),
    .word_lo(pm_rdata[DA_W-1:0]), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign req_ready = ~busy;
  assign stall     = busy;
  assign take      = req_valid & req_ready;
  assign pm_rd     = take & hit;
  assign dm_fwd    = take & ~hit;
  assign unused_hi = ^pm_rdata[PW_W-1:DA_W];
endmodule

// File: rtl/pgwin_mapper_chk.sv
module pgwin_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [15:0] req_addr,
  input logic        tbl_busy,
  input logic        loop_active,
  input logic        iter_first,
  input logic        iter_last,
  input logic        iter_irq_exit,
  input logic        iter_reentry,
  input logic        dm_fwd,
  input logic        pm_rd,
  input logic [23:0] pm_addr,
  input logic        stall,
  input logic        rsp_valid
);
  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_rd && dm_fwd));
  p_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[15]) |-> !pm_rd);
  p_tbl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_busy |-> !pm_rd);
  p_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd |-> (pm_addr[14:0] == req_addr[14:0] && !pm_addr[23]));
  p_stall_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stall, 2) && $past(stall)) |-> !stall);
  p_stall_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(pm_rd));
  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> rsp_valid);
  p_body_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rd && loop_active && !(iter_first || iter_last || iter_irq_exit || iter_reentry))
      |=> !stall);
endmodule

bind pgwin_mapper pgwin_mapper_chk u_chk (.*);

// File: tb/pgwin_mapper_tb.sv
`timescale 1ns/100ps
module pgwin_mapper_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 0;
  logic req_valid = 0, req_ready;
  logic [15:0] req_addr = 0;
  logic req_fast_cls = 0, tbl_busy = 0, loop_active = 0;
  logic iter_first = 0, iter_last = 0, iter_irq_exit = 0, iter_reentry = 0;
  logic dm_fwd, pm_rd, stall, rsp_valid;
  logic [23:0] pm_addr, pm_rdata;
  logic [15:0] rsp_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pgwin_mapper u_dut (.*);

  function automatic logic [23:0] pmf(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[15:0] ^ 16'h3C5A};
  endfunction

  // program memory model: one-cycle read latency, data held until next fetch
  always_ff @(posedge clk) if (pm_rd) pm_rdata <= pmf(pm_addr);
  initial pm_rdata = 24'h0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  // drives one request and checks every cycle until it completes
  task automatic do_req(input logic [15:0] a, input logic lp, fs, f1, fl, fx, fr, tb,
                        input logic exp_map, input int pen, input logic [7:0] pg,
                        input string tag, input bit cfg_same = 0, input logic [7:0] cfg_d = 0);
    logic [23:0] ea;
    ea = {1'b0, pg, a[14:0]};
    @(negedge clk);
    req_valid = 1; req_addr = a; loop_active = lp; req_fast_cls = fs;
    iter_first = f1; iter_last = fl; iter_irq_exit = fx; iter_reentry = fr; tbl_busy = tb;
    if (cfg_same) begin cfg_we = 1; cfg_sel = 0; cfg_wdata = cfg_d; end
    #1;
    chk(req_ready == 1'b1, {tag, " R6 ready"}, req_ready, 1);
    chk(pm_rd == exp_map, {tag, " R1 pm_rd"}, pm_rd, exp_map);
    chk(dm_fwd == !exp_map, {tag, " R1 dm_fwd"}, dm_fwd, !exp_map);
    if (exp_map) chk(pm_addr == ea, {tag, " R2 pm_addr"}, pm_addr, ea);
    @(negedge clk);
    req_valid = 0; cfg_we = 0; tbl_busy = 0;
    #1;
    if (exp_map) begin
      for (int k = 1; k <= pen + 1; k++) begin
        if (k > 1) begin @(negedge clk); #1; end
        chk(stall == (k <= pen), {tag, " R6 stall"}, stall, (k <= pen));
        chk(req_ready == !(k <= pen), {tag, " R6 ready"}, req_ready, !(k <= pen));
        chk(rsp_valid == (k == pen + 1), {tag, " R6 strobe"}, rsp_valid, (k == pen + 1));
        if (k == pen + 1)
          chk(rsp_data == pmf(ea)[15:0], {tag, " R3 data"}, rsp_data, pmf(ea)[15:0]);
      end
      @(negedge clk); #1;
      chk(rsp_valid == 0, {tag, " R6 single strobe"}, rsp_valid, 0);
    end else begin
      chk(stall == 0, {tag, " R1 no stall"}, stall, 0);
      chk(rsp_valid == 0, {tag, " R1 no strobe"}, rsp_valid, 0);
    end
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic lp, fs, f1, fl, fx, fr, tb;
    logic map;
    logic [1:0] pen;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h8000, 0,1,0,0,0,0,0, 1, 2'd1},  // R4 fast outside loop
    '{16'hFFFE, 0,0,0,0,0,0,0, 1, 2'd2},  // R4 other class
    '{16'h8002, 1,0,0,0,0,0,0, 1, 2'd0},  // R5 mid-loop
    '{16'h8004, 1,0,1,0,0,0,0, 1, 2'd2},  // R5 first
    '{16'h8006, 1,0,0,1,0,0,0, 1, 2'd2},  // R5 last
    '{16'h8008, 1,0,0,0,1,0,0, 1, 2'd2},  // R5 interrupt exit
    '{16'h800A, 1,0,0,0,0,1,0, 1, 2'd2},  // R5 re-entry
    '{16'h7FFE, 0,1,0,0,0,0,0, 0, 2'd0},  // R1 low half
    '{16'hC000, 0,1,0,0,0,0,1, 0, 2'd0},  // R7 table busy
    '{16'h8010, 1,1,0,0,0,0,0, 1, 2'd0},  // R5 class ignored in loop
    '{16'h9234, 0,1,1,1,0,0,0, 1, 2'd1}   // R4 flags ignored outside loop
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    chk(stall == 0, "R9 reset stall", stall, 0);
    chk(rsp_valid == 0, "R9 reset strobe", rsp_valid, 0);
    chk(req_ready == 1, "R9 reset ready", req_ready, 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R9: enable is 0 after reset, so a high address is not mapped
    do_req(16'h8000, 0,1,0,0,0,0,0, 0, 0, 8'h00, "R9 en off");
    cfg_wr(1'b1, 8'h01);
    // R9: page resets to 0
    do_req(16'h8100, 0,1,0,0,0,0,0, 1, 1, 8'h00, "R9 page0");
    cfg_wr(1'b0, 8'h5A);
    for (int i = 0; i < NV; i++)
      do_req(VECS[i].addr, VECS[i].lp, VECS[i].fs, VECS[i].f1, VECS[i].fl,
             VECS[i].fx, VECS[i].fr, VECS[i].tb, VECS[i].map, int'(VECS[i].pen),
             8'h5A, $sformatf("vec%0d", i));
    // R8: page write in the accept cycle affects only the next request
    do_req(16'hA000, 0,0,0,0,0,0,0, 1, 2, 8'h5A, "R8 same-cycle", 1, 8'h11);
    do_req(16'hA002, 0,1,0,0,0,0,0, 1, 1, 8'h11, "R8 new page");
    // R3: upper program byte differs from low data, only low 16 bits returned
    do_req(16'hFFFF, 1,0,0,0,0,0,0, 1, 0, 8'h11, "R3 odd addr");
    // R8: clearing enable turns the window off
    cfg_wr(1'b1, 8'h00);
    do_req(16'h8000, 0,1,0,0,0,0,0, 0, 0, 8'h11, "R8 en clear");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule